// File: doc/BRIEF.md
# Per-Element Saturating Clamp Unit

This block sits at the end of a vector element's integer datapath. It takes the wide intermediate result of one element, computed one bit wider than the widest destination element. It then narrows that result into the destination element width selected for the operation. When the operation's mode field asks for saturation, out-of-range values are pinned to the destination's minimum or maximum instead of wrapping. The clamp range is signed or unsigned, chosen by a sign bit in the mode field. When saturation is not requested the value is simply truncated.

For every element the unit also produces a saturation flag meant for that element's own condition field. The flag reports only whether this element was clamped. It never folds in any sticky overflow history, so elements stay independent of one another. The unit also raises an illegal-operation indication when saturation is combined with overflow-enable, because both would claim the same condition bit. Carry outputs are forced to zero whenever saturation is requested. All results are registered, one cycle after the input is presented.

Top module: `sat_clamp_unit`

## Requirements
- R1: With mode bits [4:3] = 2'b10 and mode bit [2] = 0 (unsigned saturation), an input below 0 yields 0, an input above 2^w-1 yields 2^w-1, and any other input passes unchanged (w = destination width).
- R2: With mode bits [4:3] = 2'b10 and mode bit [2] = 1 (signed saturation), the input is clamped to the range -2^(w-1) .. 2^(w-1)-1; the result is placed as a w-bit two's complement pattern in out_val_o[w-1:0], with all higher bits zero.
- R3: The width code elw_i selects the destination width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits; out_val_o bits at and above w are always 0.
- R4: sat_flag_o is 1 exactly when saturation is requested, rec_en_i is 1 and the value was clamped; otherwise it is 0, with no dependence on earlier elements.
- R5: illegal_o is 1 exactly when saturation is requested (mode bits [4:3] = 2'b10) and ovf_en_i is 1.
- R6: When saturation is requested, carry_o and carry32_o are 0; otherwise carry_o is input bit w and carry32_o is input bit 32.
- R7: When mode bits [4:3] differ from 2'b10, out_val_o is the low w bits of the input and sat_flag_o is 0.
- R8: Outputs update on the rising edge after in_valid_i = 1; out_valid_o is in_valid_i delayed by one cycle; while in_valid_i = 0 the data outputs hold.
- R9: A synchronous active-high reset clears every output to 0.
- R10: Mode bits [1:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Element present this cycle |
| wide_i | input | 65 | Wide intermediate result, two's complement |
| mode_i | input | 5 | Mode field: [4:3] class, [2] sign select, [1:0] unused here |
| rec_en_i | input | 1 | Record enable for the saturation flag |
| ovf_en_i | input | 1 | Overflow enable of the operation |
| elw_i | input | 2 | Destination width code |
| out_valid_o | output | 1 | Result registered this cycle |
| out_val_o | output | 64 | Clamped or truncated element, zero above width |
| sat_flag_o | output | 1 | Element saturation flag |
| illegal_o | output | 1 | Illegal option combination |
| carry_o | output | 1 | Carry out of the destination width |
| carry32_o | output | 1 | Carry out of bit 31 |

## Verification
The bench builds the unit with its default 64-bit data width, so the 65-bit intermediate can reach every width code up to the full 64-bit destination. That includes the edge where the unsigned maximum needs the extra top bit to be represented. Random values are biased toward each width's signed and unsigned bounds plus or minus two, so the one-off compare edges for all four widths and both signs are reached along with fully random wide values.

// File: rtl/sat_clamp_pkg.sv
package sat_clamp_pkg;

    localparam int unsigned NUM_WIDTHS = 4;
    localparam int unsigned BASE_W     = 8;

    localparam logic [1:0] CLASS_SAT = 2'b10;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } elw_e;

    typedef struct packed {
        logic sat_req;
        logic signed_mode;
        logic rec_en;
        logic ovf_en;
        elw_e width;
    } clamp_ctrl_t;

    function automatic int unsigned width_bits(input int unsigned code);
        return BASE_W << code;
    endfunction

    function automatic int unsigned clip_width(input int unsigned code, input int unsigned max_w);
        return (width_bits(code) > max_w) ? max_w : width_bits(code);
    endfunction

endpackage

// File: rtl/sat_mode_decode.sv
module sat_mode_decode
    import sat_clamp_pkg::*;
(
    input  logic [4:0]  mode,
    input  logic        rec_en,
    input  logic        ovf_en,
    input  logic [1:0]  elw,
    output clamp_ctrl_t ctrl,
    output logic        illegal
);

    always_comb begin
        ctrl.sat_req     = (mode[4:3] == CLASS_SAT);
        ctrl.signed_mode = mode[2];
        ctrl.rec_en      = rec_en;
        ctrl.ovf_en      = ovf_en;
        ctrl.width       = elw_e'(elw);
        illegal          = ctrl.sat_req & ovf_en;
    end

endmodule

// File: rtl/sat_bound_gen.sv
module sat_bound_gen
    import sat_clamp_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned WIDE_W = DATA_W + 1
) (
    input  clamp_ctrl_t       ctrl,
    input  logic [WIDE_W-1:0] wide,
    output logic [WIDE_W-1:0] hi,
    output logic [WIDE_W-1:0] lo,
    output logic [DATA_W-1:0] mask,
    output logic              carry_w
);

    logic [WIDE_W-1:0] u_hi   [NUM_WIDTHS];
    logic [WIDE_W-1:0] s_hi   [NUM_WIDTHS];
    logic [WIDE_W-1:0] s_lo   [NUM_WIDTHS];
    logic [DATA_W-1:0] w_mask [NUM_WIDTHS];
    logic              w_cy   [NUM_WIDTHS];

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        localparam int unsigned EW = clip_width(g, DATA_W);
        logic [WIDE_W-1:0] top_bit;
        logic [WIDE_W-1:0] half_bit;

        assign top_bit   = WIDE_W'(1) << EW;
        assign half_bit  = WIDE_W'(1) << (EW - 1);
        assign u_hi[g]   = top_bit - WIDE_W'(1);
        assign s_hi[g]   = half_bit - WIDE_W'(1);
        assign s_lo[g]   = ~s_hi[g];
        assign w_mask[g] = u_hi[g][DATA_W-1:0];
        assign w_cy[g]   = wide[EW];
    end

    always_comb begin
        hi      = ctrl.signed_mode ? s_hi[ctrl.width] : u_hi[ctrl.width];
        lo      = ctrl.signed_mode ? s_lo[ctrl.width] : '0;
        mask    = w_mask[ctrl.width];
        carry_w = w_cy[ctrl.width];
    end

endmodule

// File: rtl/sat_clamp_select.sv
module sat_clamp_select
    import sat_clamp_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned WIDE_W = DATA_W + 1
) (
    input  clamp_ctrl_t       ctrl,
    input  logic [WIDE_W-1:0] wide,
    input  logic [WIDE_W-1:0] hi,
    input  logic [WIDE_W-1:0] lo,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] value,
    output logic              clamped
);

    logic above;
    logic below;

    always_comb begin
        above = $signed(wide) > $signed(hi);
        below = $signed(wide) < $signed(lo);
        if (!ctrl.sat_req) begin
            value   = wide[DATA_W-1:0] & mask;
            clamped = 1'b0;
        end else if (above) begin
            value   = hi[DATA_W-1:0] & mask;
            clamped = 1'b1;
        end else if (below) begin
            value   = lo[DATA_W-1:0] & mask;
            clamped = 1'b1;
        end else begin
            value   = wide[DATA_W-1:0] & mask;
            clamped = 1'b0;
        end
    end

endmodule

// File: rtl/sat_clamp_unit.sv
module sat_clamp_unit
    import sat_clamp_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [DATA_W:0]   wide_i,
    input  logic [4:0]        mode_i,
    input  logic              rec_en_i,
    input  logic              ovf_en_i,
    input  logic [1:0]        elw_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_val_o,
    output logic              sat_flag_o,
    output logic              illegal_o,
    output logic              carry_o,
    output logic              carry32_o
);

    localparam int unsigned WIDE_W = DATA_W + 1;
    localparam int unsigned C32    = (DATA_W > 32) ? 32 : DATA_W - 1;

    clamp_ctrl_t       ctrl;
    logic              illegal_c;
    logic [WIDE_W-1:0] hi;
    logic [WIDE_W-1:0] lo;
    logic [DATA_W-1:0] mask;
    logic              carry_w;
    logic [DATA_W-1:0] value;
    logic              clamped;

    sat_mode_decode i_decode (
        .mode    (mode_i),
        .rec_en  (rec_en_i),
        .ovf_en  (ovf_en_i),
        .elw     (elw_i),
        .ctrl    (ctrl),
        .illegal (illegal_c)
    );

    sat_bound_gen #(.DATA_W(DATA_W)) i_bounds (
        .ctrl    (ctrl),
        .wide    (wide_i),
        .hi      (hi),
        .lo      (lo),
        .mask    (mask),
        .carry_w (carry_w)
    );

    sat_clamp_select #(.DATA_W(DATA_W)) i_select (
        .ctrl    (ctrl),
        .wide    (wide_i),
        .hi      (hi),
        .lo      (lo),
        .mask    (mask),
        .value   (value),
        .clamped (clamped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            out_val_o   <= '0;
            sat_flag_o  <= 1'b0;
            illegal_o   <= 1'b0;
            carry_o     <= 1'b0;
            carry32_o   <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                out_val_o  <= value;
                sat_flag_o <= ctrl.sat_req & ctrl.rec_en & clamped;
                illegal_o  <= illegal_c;
                carry_o    <= ~ctrl.sat_req & carry_w;
                carry32_o  <= ~ctrl.sat_req & wide_i[C32];
            end
        end
    end

endmodule

// File: rtl/sat_clamp_checker.sv
module sat_clamp_checker #(
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid_i,
    input logic [DATA_W:0]   wide_i,
    input logic [4:0]        mode_i,
    input logic              rec_en_i,
    input logic              ovf_en_i,
    input logic [1:0]        elw_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] out_val_o,
    input logic              sat_flag_o,
    input logic              illegal_o,
    input logic              carry_o,
    input logic              carry32_o
);

    assert_unsigned_negative_zero_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && mode_i[4:2] == 3'b100 && wide_i[DATA_W] |=> out_val_o == '0);

    assert_signed_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && mode_i[4:2] == 3'b101 && elw_i == 2'd0 |=> out_val_o[DATA_W-1:8] == '0);

    assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && elw_i == 2'd1 |=> out_val_o[DATA_W-1:16] == '0);

    assert_no_flag_without_record_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && !rec_en_i |=> !sat_flag_o);

    assert_illegal_match_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> illegal_o == ($past(mode_i[4:3]) == 2'b10 && $past(ovf_en_i)));

    assert_no_carry_on_sat_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && mode_i[4:3] == 2'b10 |=> !carry_o && !carry32_o);

    assert_no_flag_without_sat_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && mode_i[4:3] != 2'b10 |=> !sat_flag_o);

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid_o == $past(in_valid_i));

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> $stable(out_val_o) && $stable(sat_flag_o) && $stable(illegal_o));

endmodule

bind sat_clamp_unit sat_clamp_checker #(.DATA_W(DATA_W)) i_sat_clamp_checker (.*);

// File: tb/test_sat_clamp_unit.sv
module test_sat_clamp_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid_i;
    logic [DW:0]   wide_i;
    logic [4:0]    mode_i;
    logic          rec_en_i;
    logic          ovf_en_i;
    logic [1:0]    elw_i;
    logic          out_valid_o;
    logic [DW-1:0] out_val_o;
    logic          sat_flag_o;
    logic          illegal_o;
    logic          carry_o;
    logic          carry32_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sat_clamp_unit #(.DATA_W(DW)) i_sat_clamp_unit (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .wide_i(wide_i),
        .mode_i(mode_i), .rec_en_i(rec_en_i), .ovf_en_i(ovf_en_i), .elw_i(elw_i),
        .out_valid_o(out_valid_o), .out_val_o(out_val_o), .sat_flag_o(sat_flag_o),
        .illegal_o(illegal_o), .carry_o(carry_o), .carry32_o(carry32_o)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] code);
        return 8 << code;
    endfunction

    // Reference clamp computed with 66-bit signed arithmetic
    function automatic logic [DW:0] model(input logic [DW:0] wide, input bit sat, input bit sgn,
                                          input logic [1:0] code);
        int w = wbits(code);
        logic signed [65:0] x = $signed({wide[DW], wide});
        logic signed [65:0] top, bot, r;
        bit cl = 1'b0;
        logic [DW-1:0] m;
        if (sgn) begin
            top = (66'sd1 <<< (w - 1)) - 66'sd1;
            bot = -(66'sd1 <<< (w - 1));
        end else begin
            top = (66'sd1 <<< w) - 66'sd1;
            bot = 66'sd0;
        end
        r = x;
        if (sat && x > top) begin r = top; cl = 1'b1; end
        if (sat && x < bot) begin r = bot; cl = 1'b1; end
        m = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
        return {cl, r[DW-1:0] & m};
    endfunction

    task automatic apply_check(input logic [DW:0] wide, input logic [4:0] mode, input bit rec,
                               input bit ovf, input logic [1:0] code, input string tag);
        logic [DW:0] e;
        bit sat = (mode[4:3] == 2'b10);
        int w = wbits(code);
        e = model(wide, sat, mode[2], code);
        @(negedge clk);
        in_valid_i = 1'b1; wide_i = wide; mode_i = mode;
        rec_en_i = rec; ovf_en_i = ovf; elw_i = code;
        @(negedge clk);
        in_valid_i = 1'b0;
        chk({tag, " value"}, out_val_o, e[DW-1:0]);
        chk("R4 flag", DW'(sat_flag_o), DW'(sat & rec & e[DW]));
        chk("R5 illegal", DW'(illegal_o), DW'(sat & ovf));
        chk("R6 carry", DW'(carry_o), DW'(sat ? 1'b0 : wide[w]));
        chk("R6 carry32", DW'(carry32_o), DW'(sat ? 1'b0 : wide[32]));
        chk("R8 valid", DW'(out_valid_o), DW'(1));
    endtask

    function automatic logic [DW:0] near_bound(input logic [1:0] code, input bit sgn);
        int w = wbits(code);
        logic signed [65:0] b;
        int pick = $urandom_range(0, 1);
        int off = $urandom_range(0, 4) - 2;
        if (sgn) b = pick ? ((66'sd1 <<< (w - 1)) - 66'sd1) : -(66'sd1 <<< (w - 1));
        else     b = pick ? ((66'sd1 <<< w) - 66'sd1) : 66'sd0;
        b = b + 66'(signed'(off));
        return b[DW:0];
    endfunction

    initial begin
        logic [DW-1:0] held;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid_i = 1'b0; wide_i = '0; mode_i = '0;
        rec_en_i = 1'b0; ovf_en_i = 1'b0; elw_i = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 value", out_val_o, '0);
        chk("R9 valid", DW'(out_valid_o), '0);
        chk("R9 flags", DW'({sat_flag_o, illegal_o, carry_o, carry32_o}), '0);
        rst = 1'b0;

        // R1 unsigned directed
        apply_check(-65'sd5, 5'b10000, 1, 0, 2'd0, "R1 neg");
        apply_check(65'd300, 5'b10000, 1, 0, 2'd0, "R1 over");
        apply_check(65'd255, 5'b10000, 1, 0, 2'd0, "R1 edge");
        apply_check({1'b0, {64{1'b1}}}, 5'b10000, 1, 0, 2'd3, "R1 max64");
        apply_check({1'b1, 64'd0}, 5'b10000, 1, 0, 2'd3, "R1 min65");
        // R2 signed directed
        apply_check(65'd128, 5'b10100, 1, 0, 2'd0, "R2 over");
        apply_check(-65'sd129, 5'b10100, 1, 0, 2'd0, "R2 under");
        apply_check(-65'sd1, 5'b10100, 1, 0, 2'd1, "R2 inrange");
        apply_check({2'b00, {63{1'b1}}} + 65'd1, 5'b10100, 1, 0, 2'd3, "R2 over64");
        // R3 widths
        apply_check(65'h1_2345_6789_abcd_ef01, 5'b00000, 0, 0, 2'd1, "R3 w16");
        apply_check(65'h1_2345_6789_abcd_ef01, 5'b00000, 0, 0, 2'd2, "R3 w32");
        // R4 record off with clamp
        apply_check(65'd999, 5'b10000, 0, 0, 2'd0, "R4 norec");
        // R5 illegal combination, and ovf without saturation
        apply_check(65'd7, 5'b10000, 1, 1, 2'd0, "R5 sat ovf");
        apply_check(65'd7, 5'b01000, 1, 1, 2'd0, "R5 nosat ovf");
        // R7 truncation with carries
        apply_check(65'h0_0000_0001_0000_01ff, 5'b11000, 1, 0, 2'd0, "R7 trunc");
        // R10 low mode bits ignored
        apply_check(65'd300, 5'b10011, 1, 0, 2'd0, "R10 low bits");
        apply_check(-65'sd300, 5'b10111, 1, 0, 2'd0, "R10 low bits signed");

        // R8 hold while idle
        held = out_val_o;
        @(negedge clk);
        wide_i = 65'd12345; mode_i = 5'b00000; elw_i = 2'd3;
        @(negedge clk);
        chk("R8 hold", out_val_o, held);
        chk("R8 idle valid", DW'(out_valid_o), '0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [DW:0] v;
            logic [1:0]  code = 2'($urandom_range(0, 3));
            logic [4:0]  mode = 5'($urandom_range(0, 31));
            if ($urandom_range(0, 2) != 0) mode[4:3] = 2'b10;
            if ($urandom_range(0, 1) == 0) v = near_bound(code, mode[2]);
            else v = {1'($urandom_range(0, 1)), $urandom(), $urandom()};
            apply_check(v, mode, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        code, mode[4:3] == 2'b10 ? (mode[2] ? "R2 rand" : "R1 rand") : "R7 rand");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule